// File: doc/BRIEF.md
# 2D Drawing Command Engine

This block runs rectangle drawing jobs on a pixel framebuffer held in a simple synchronous memory. A host pushes 32-bit command words into a small queue and waits, using the reported number of empty queue slots, until a whole command fits. Two jobs are understood. A solid fill paints a rectangle in the foreground colour. A rectangle copy moves pixels from one region to another and stays correct when the two regions overlap, because the host picks the scan direction on each axis.

The host also writes a register bank: framebuffer base address, line stride in pixels, foreground colour, pixel depth (8 or 16 bits) and an inclusive clip window. A status word shows when the engine is still working. It also keeps two sticky error flags, one for a malformed header and one for a write into a full queue. Memory is byte addressed. A read returns its data in the cycle after the request.

Top module: `gfx_cmd_engine`

## Requirements
- R1: Header word 0x09410000 starts a fill. Two argument words follow: the destination position, then the size. Every argument has Y (or height) in bits [31:16] and X (or width) in bits [15:0]. Each pixel of the rectangle is written with the foreground colour.
- R2: A header with bits [31:24] = 0x0D, bits [23:18] = 6'b010001 and bits [15:0] = 0 starts a copy. Three argument words follow: the source position, the destination position, then the size. Each destination pixel receives the value its source pixel held at the moment it was read, one read per pixel, and the write comes in the cycle after that read.
- R3: In a copy header, bit 16 set scans X from right to left, and bit 17 set scans Y from bottom to top. A fill always scans forward. X advances fastest. Memory writes occur in scan order, so overlapping copies come out correct.
- R4: The byte address of pixel (x, y) is base + (y*stride + x) * B, where B is 1 or 2. Mode register bit 15 set selects 16-bit pixels (B=2, the write carries 16 bits, mem_wide high). Clear selects 8-bit pixels, carried in data bits [7:0].
- R5: A pixel is written only when xmin <= x <= xmax and ymin <= y <= ymax, all inclusive. In a copy the clip test applies to the destination pixel, and a clipped pixel is neither read nor written.
- R6: A fill or copy whose width or height is zero finishes without any memory access.
- R7: free_slots always equals FIFO_DEPTH minus the number of queued words.
- R8: A command write while free_slots is 0 is discarded, and it sets the sticky overflow flag in status bit 30.
- R9: A header word that is neither a fill nor a copy is discarded, and it sets the sticky error flag in status bit 31. The next word is decoded as a header.
- R10: Status bits 0 (drawing), 4 (queue not empty), 5 (command partly collected or waiting) and 8 (copy write phase) are all zero only when no command is queued or running and no memory access is under way.
- R11: After reset: free_slots = FIFO_DEPTH, status = 0, no memory access, base 0, stride SCREEN_W, foreground 0, 8-bit pixels, clip window x in 0..SCREEN_W-1 and y in 0..SCREEN_H-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 base, 1 stride, 2 colour, 3 mode, 4 xmin, 5 xmax, 6 ymin, 7 ymax |
| reg_wdata | input | 32 | Register write data |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word |
| free_slots | output | $clog2(FIFO_DEPTH+1) | Empty command queue entries |
| status | output | 32 | Busy bits (mask 0x131), overflow bit 30, bad header bit 31 |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_wide | output | 1 | Access covers two bytes |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |

## Verification
The bench builds the engine with a four-entry queue, a 32x16 screen and a 16-bit address. The shallow queue can be filled completely while one long full-screen fill is running, so the zero-slot state and the discarded write are easy to reach. The small screen lets a reset-state clip window cut off a rectangle at the screen corner. A scoreboard predicts every memory write in order, including address, data and scan direction, for fills, clipped fills and overlapping copies in both pixel depths.

// File: rtl/gfx_pkg.sv
// Shared types and helpers for the drawing command engine.
// Assumes: byte addressed framebuffer, coordinates and sizes of 16 bits.
package gfx_pkg;

    localparam logic [31:0] HDR_FILL     = 32'h0941_0000;
    localparam logic [7:0]  HDR_COPY_OP  = 8'h0D;
    localparam logic [5:0]  HDR_COPY_FIX = 6'b010001;

    typedef enum logic {
        OP_FILL = 1'b0,
        OP_COPY = 1'b1
    } op_e;

    typedef enum logic [1:0] {
        EX_IDLE = 2'd0,
        EX_FILL = 2'd1,
        EX_CRD  = 2'd2,
        EX_CWR  = 2'd3
    } ex_state_e;

    typedef struct packed {
        op_e         op;
        logic        xrev;
        logic        yrev;
        logic [31:0] a0;
        logic [31:0] a1;
        logic [31:0] a2;
    } cmd_t;

    // Byte address of a pixel from its coordinates and the surface layout.
    function automatic logic [31:0] pix_addr(input logic [31:0] base,
                                             input logic [15:0] stride,
                                             input logic [16:0] x,
                                             input logic [16:0] y,
                                             input logic        wide);
        logic [31:0] lin;
        lin = 32'(y) * 32'(stride) + 32'(x);
        return base + (wide ? {lin[30:0], 1'b0} : lin);
    endfunction

endpackage

// File: rtl/gfx_cmd_fifo.sv
// Command word queue with free-slot count.
// Writes into a full queue are dropped and latch a sticky overflow flag.
// Assumes: DEPTH >= 2; the reader pops only when the queue is not empty.
module gfx_cmd_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 32,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    output logic [W-1:0]  rd_data,
    output logic          empty,
    output logic [CW-1:0] free_slots,
    output logic          overflow
);

    logic [W-1:0]  slot [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;
    logic          full, wr_ok, rd_ok;

    assign full       = (cnt == CW'(DEPTH));
    assign empty      = (cnt == '0);
    assign wr_ok      = wr_en && !full;
    assign rd_ok      = rd_en && !empty;
    assign rd_data    = slot[rptr];
    assign free_slots = CW'(DEPTH) - cnt;

    // One storage register per slot, loaded when the write pointer selects it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_ok && wptr == PW'(g)) slot[g] <= wr_data;
        end
    end

    // Pointer, occupancy and overflow flag bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr     <= '0;
            rptr     <= '0;
            cnt      <= '0;
            overflow <= 1'b0;
        end else begin
            if (wr_ok) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (rd_ok) rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            if (wr_ok && !rd_ok)      cnt <= cnt + 1'b1;
            else if (rd_ok && !wr_ok) cnt <= cnt - 1'b1;
            if (wr_en && full) overflow <= 1'b1;
        end
    end

    // R7
    fifo_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R8
    full_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> (cnt == CW'(DEPTH) && overflow));

endmodule

// File: rtl/gfx_cmd_parser.sv
// Turns the command word stream into complete commands.
// Decodes the header, collects the argument words, then holds the command
// until the drawing unit takes it. Unknown headers are dropped and flagged.
// Assumes: the queue's read data is valid whenever it is not empty.
module gfx_cmd_parser
    import gfx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        q_empty,
    input  logic [31:0] q_data,
    output logic        q_pop,
    output logic        cmd_valid,
    output cmd_t        cmd,
    input  logic        cmd_ready,
    output logic        bad_hdr,
    output logic        collecting
);

    logic [1:0]  need;
    logic [1:0]  idx;
    logic        pend;
    op_e         op_q;
    logic        xrev_q, yrev_q;
    logic [31:0] arg0, arg1, arg2;
    logic        is_fill, is_copy;

    assign is_fill = (q_data == HDR_FILL);
    assign is_copy = (q_data[31:24] == HDR_COPY_OP) &&
                     (q_data[23:18] == HDR_COPY_FIX) &&
                     (q_data[15:0] == 16'h0);

    assign q_pop      = !q_empty && !pend;
    assign cmd_valid  = pend;
    assign collecting = pend || (need != 2'd0);
    assign cmd        = '{op: op_q, xrev: xrev_q, yrev: yrev_q,
                          a0: arg0, a1: arg1, a2: arg2};

    // Header decode and argument collection state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            need    <= 2'd0;
            idx     <= 2'd0;
            pend    <= 1'b0;
            op_q    <= OP_FILL;
            xrev_q  <= 1'b0;
            yrev_q  <= 1'b0;
            arg0    <= '0;
            arg1    <= '0;
            arg2    <= '0;
            bad_hdr <= 1'b0;
        end else begin
            if (pend && cmd_ready) pend <= 1'b0;
            if (q_pop) begin
                if (need == 2'd0) begin
                    idx <= 2'd0;
                    if (is_fill) begin
                        need   <= 2'd2;
                        op_q   <= OP_FILL;
                        xrev_q <= 1'b0;
                        yrev_q <= 1'b0;
                    end else if (is_copy) begin
                        need   <= 2'd3;
                        op_q   <= OP_COPY;
                        xrev_q <= q_data[16];
                        yrev_q <= q_data[17];
                    end else begin
                        bad_hdr <= 1'b1;
                    end
                end else begin
                    case (idx)
                        2'd0:    arg0 <= q_data;
                        2'd1:    arg1 <= q_data;
                        default: arg2 <= q_data;
                    endcase
                    idx  <= idx + 1'b1;
                    need <= need - 1'b1;
                    if (need == 2'd1) pend <= 1'b1;
                end
            end
        end
    end

    // R9
    bad_header_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_pop && need == 2'd0 && !is_fill && !is_copy) |=> (bad_hdr && need == 2'd0));

    // R1
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd)));

endmodule

// File: rtl/gfx_draw_exec.sv
// Rectangle walker: scans a fill or copy pixel by pixel in the direction
// the command asks for, clips against the window and drives the memory port.
// Fill writes one pixel per cycle; a copy spends a read cycle and a write cycle.
// Assumes: the register bank is not rewritten while a command runs;
// memory read data arrives in the cycle after the read request.
module gfx_draw_exec
    import gfx_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  cmd_t          cmd,
    output logic          cmd_ready,
    input  logic [31:0]   base,
    input  logic [15:0]   stride,
    input  logic [15:0]   fg,
    input  logic          wide,
    input  logic [15:0]   xmin,
    input  logic [15:0]   xmax,
    input  logic [15:0]   ymin,
    input  logic [15:0]   ymax,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    input  logic [15:0]   mem_rdata,
    output logic          busy,
    output logic          wr_phase
);

    ex_state_e   st;
    logic [15:0] sx, sy, dx, dy, w, h, i, j;
    logic        xrev, yrev;
    logic [15:0] xo, yo, nxt_i, nxt_j;
    logic [16:0] px, py, qx, qy;
    logic        in_clip, last;
    logic [31:0] dst_a, src_a;
    logic [31:0] c_dst, c_size;

    // Scan offsets, pixel coordinates and loop bounds for the current step.
    always_comb begin
        xo      = xrev ? (w - 16'd1 - i) : i;
        yo      = yrev ? (h - 16'd1 - j) : j;
        px      = {1'b0, dx} + {1'b0, xo};
        py      = {1'b0, dy} + {1'b0, yo};
        qx      = {1'b0, sx} + {1'b0, xo};
        qy      = {1'b0, sy} + {1'b0, yo};
        in_clip = (px >= {1'b0, xmin}) && (px <= {1'b0, xmax}) &&
                  (py >= {1'b0, ymin}) && (py <= {1'b0, ymax});
        last    = (i == w - 16'd1) && (j == h - 16'd1);
        nxt_i   = (i == w - 16'd1) ? 16'd0 : i + 16'd1;
        nxt_j   = (i == w - 16'd1) ? j + 16'd1 : j;
        dst_a   = pix_addr(base, stride, px, py, wide);
        src_a   = pix_addr(base, stride, qx, qy, wide);
    end

    // Argument roles differ between the two command kinds.
    assign c_dst  = (cmd.op == OP_COPY) ? cmd.a1 : cmd.a0;
    assign c_size = (cmd.op == OP_COPY) ? cmd.a2 : cmd.a1;

    assign cmd_ready = (st == EX_IDLE);
    assign busy      = (st != EX_IDLE);
    assign wr_phase  = (st == EX_CWR);

    // Memory port drive for the current state.
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = dst_a[AW-1:0];
        mem_wdata = wide ? fg : {8'h00, fg[7:0]};
        case (st)
            EX_FILL: begin
                mem_en = in_clip;
                mem_we = in_clip;
            end
            EX_CRD: begin
                mem_en   = in_clip;
                mem_addr = src_a[AW-1:0];
            end
            EX_CWR: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = wide ? mem_rdata : {8'h00, mem_rdata[7:0]};
            end
            default: ;
        endcase
    end

    // Command acceptance and pixel scan sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= EX_IDLE;
            sx   <= '0;
            sy   <= '0;
            dx   <= '0;
            dy   <= '0;
            w    <= '0;
            h    <= '0;
            i    <= '0;
            j    <= '0;
            xrev <= 1'b0;
            yrev <= 1'b0;
        end else begin
            case (st)
                EX_IDLE: if (cmd_valid) begin
                    sx   <= cmd.a0[15:0];
                    sy   <= cmd.a0[31:16];
                    dx   <= c_dst[15:0];
                    dy   <= c_dst[31:16];
                    w    <= c_size[15:0];
                    h    <= c_size[31:16];
                    xrev <= cmd.xrev;
                    yrev <= cmd.yrev;
                    i    <= '0;
                    j    <= '0;
                    if (c_size[15:0] != 16'd0 && c_size[31:16] != 16'd0)
                        st <= (cmd.op == OP_COPY) ? EX_CRD : EX_FILL;
                end
                EX_FILL: begin
                    i <= nxt_i;
                    j <= nxt_j;
                    if (last) st <= EX_IDLE;
                end
                EX_CRD: begin
                    if (in_clip) begin
                        st <= EX_CWR;
                    end else begin
                        i <= nxt_i;
                        j <= nxt_j;
                        if (last) st <= EX_IDLE;
                    end
                end
                default: begin
                    i  <= nxt_i;
                    j  <= nxt_j;
                    st <= last ? EX_IDLE : EX_CRD;
                end
            endcase
        end
    end

    // R6
    zero_size_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == EX_IDLE && cmd_valid &&
         (c_size[15:0] == 16'd0 || c_size[31:16] == 16'd0)) |=> (st == EX_IDLE && !mem_en));

    // R2
    copy_write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == EX_CWR) |-> ($past(st) == EX_CRD && $past(mem_en) && !$past(mem_we)));

endmodule

// File: rtl/gfx_cmd_engine.sv
// Top of the drawing command engine: register bank, command queue,
// command parser and rectangle walker, plus the status word.
// Assumes: registers are written only while the engine is idle.
module gfx_cmd_engine
    import gfx_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int AW         = 24,
    parameter int SCREEN_W   = 640,
    parameter int SCREEN_H   = 480,
    localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_sel,
    input  logic [31:0]   reg_wdata,
    input  logic          cmd_we,
    input  logic [31:0]   cmd_wdata,
    output logic [CW-1:0] free_slots,
    output logic [31:0]   status,
    output logic          mem_en,
    output logic          mem_we,
    output logic          mem_wide,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    input  logic [15:0]   mem_rdata
);

    logic [31:0] r_base;
    logic [15:0] r_stride, r_fg, r_xmin, r_xmax, r_ymin, r_ymax;
    logic        r_wide;

    logic        q_empty, q_pop, q_ovf;
    logic [31:0] q_data;
    logic        cmd_valid, cmd_ready, bad_hdr, collecting;
    cmd_t        cmd;
    logic        ex_busy, ex_wr;

    // Host register bank with full-screen reset window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_base   <= '0;
            r_stride <= 16'(SCREEN_W);
            r_fg     <= '0;
            r_wide   <= 1'b0;
            r_xmin   <= '0;
            r_xmax   <= 16'(SCREEN_W - 1);
            r_ymin   <= '0;
            r_ymax   <= 16'(SCREEN_H - 1);
        end else if (reg_we) begin
            case (reg_sel)
                3'd0: r_base   <= reg_wdata;
                3'd1: r_stride <= reg_wdata[15:0];
                3'd2: r_fg     <= reg_wdata[15:0];
                3'd3: r_wide   <= reg_wdata[15];
                3'd4: r_xmin   <= reg_wdata[15:0];
                3'd5: r_xmax   <= reg_wdata[15:0];
                3'd6: r_ymin   <= reg_wdata[15:0];
                default: r_ymax <= reg_wdata[15:0];
            endcase
        end
    end

    gfx_cmd_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cmd_we),
        .wr_data    (cmd_wdata),
        .rd_en      (q_pop),
        .rd_data    (q_data),
        .empty      (q_empty),
        .free_slots (free_slots),
        .overflow   (q_ovf)
    );

    gfx_cmd_parser u_parser (
        .clk        (clk),
        .rst_n      (rst_n),
        .q_empty    (q_empty),
        .q_data     (q_data),
        .q_pop      (q_pop),
        .cmd_valid  (cmd_valid),
        .cmd        (cmd),
        .cmd_ready  (cmd_ready),
        .bad_hdr    (bad_hdr),
        .collecting (collecting)
    );

    gfx_draw_exec #(.AW(AW)) u_exec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .cmd_ready (cmd_ready),
        .base      (r_base),
        .stride    (r_stride),
        .fg        (r_fg),
        .wide      (r_wide),
        .xmin      (r_xmin),
        .xmax      (r_xmax),
        .ymin      (r_ymin),
        .ymax      (r_ymax),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .busy      (ex_busy),
        .wr_phase  (ex_wr)
    );

    assign mem_wide = r_wide;

    // Status word: busy bits in mask 0x131 and two sticky error flags.
    assign status = {bad_hdr, q_ovf, 21'd0, ex_wr, 2'd0,
                     collecting, !q_empty, 3'd0, ex_busy};

    // R10
    mem_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> ((status & 32'h0000_0131) != 32'd0));

endmodule

// File: tb/gfx_cmd_engine_test.sv
// Scoreboard bench: command tasks push predicted memory writes into a queue,
// a monitor pops and compares each write the engine makes.
module gfx_cmd_engine_test;

    localparam int DEPTH = 4;
    localparam int AW    = 16;
    localparam int SW    = 32;
    localparam int SH    = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_sel = '0;
    logic [31:0]   reg_wdata = '0;
    logic          cmd_we = 1'b0;
    logic [31:0]   cmd_wdata = '0;
    logic [CW-1:0] free_slots;
    logic [31:0]   status;
    logic          mem_en, mem_we, mem_wide;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata;
    logic [15:0]   mem_rdata = '0;

    int checks = 0;
    int errors = 0;

    logic [7:0]  mem  [4096];
    logic [7:0]  smem [4096];
    logic [31:0] exp_q [$];

    // Bench copy of the register bank.
    int m_base = 0, m_stride = SW, m_fg = 0, m_wide = 0;
    int m_xmin = 0, m_xmax = SW - 1, m_ymin = 0, m_ymax = SH - 1;

    gfx_cmd_engine #(.FIFO_DEPTH(DEPTH), .AW(AW), .SCREEN_W(SW), .SCREEN_H(SH)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .cmd_we     (cmd_we),
        .cmd_wdata  (cmd_wdata),
        .free_slots (free_slots),
        .status     (status),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_wide   (mem_wide),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata)
    );

    always #4 clk = ~clk;

    // Synchronous memory model, read data one cycle after the request.
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                mem[mem_addr[11:0]] <= mem_wdata[7:0];
                if (mem_wide) mem[mem_addr[11:0] + 12'd1] <= mem_wdata[15:8];
            end else begin
                mem_rdata <= {mem[mem_addr[11:0] + 12'd1], mem[mem_addr[11:0]]};
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: every engine write must match the head of the expected queue.
    always @(negedge clk) begin
        if (rst_n && mem_en && mem_we) begin
            logic [31:0] got;
            got = {mem_addr, mem_wide ? mem_wdata : {8'h00, mem_wdata[7:0]}};
            if (exp_q.size() == 0) begin
                check(1'b0, "R1-write unexpected (R5/R6)", got, 32'h0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check(got == e, "R2/R3/R4 write addr:data", got, e);
            end
        end
    end

    function automatic int paddr(input int x, input int y);
        return (m_base + (y * m_stride + x) * (m_wide ? 2 : 1)) & 16'hFFFF;
    endfunction

    function automatic bit inwin(input int x, input int y);
        return x >= m_xmin && x <= m_xmax && y >= m_ymin && y <= m_ymax;
    endfunction

    task automatic wr_reg(input logic [2:0] sel, input int val);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = 32'(val);
        @(negedge clk);
        reg_we = 1'b0;
        case (sel)
            3'd0: m_base = val;
            3'd1: m_stride = val;
            3'd2: m_fg = val;
            3'd3: m_wide = (val >> 15) & 1;
            3'd4: m_xmin = val;
            3'd5: m_xmax = val;
            3'd6: m_ymin = val;
            default: m_ymax = val;
        endcase
    endtask

    task automatic push(input logic [31:0] w);
        while (free_slots == '0) @(negedge clk);
        cmd_we = 1'b1; cmd_wdata = w;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    // Driver for a fill: predicts the writes, then sends the words (R1).
    task automatic do_fill(input int x, input int y, input int w, input int h);
        for (int jj = 0; jj < h; jj++)
            for (int ii = 0; ii < w; ii++)
                if (inwin(x + ii, y + jj)) begin
                    int a, d;
                    a = paddr(x + ii, y + jj);
                    d = m_wide ? (m_fg & 16'hFFFF) : (m_fg & 8'hFF);
                    smem[a[11:0]] = 8'(d);
                    if (m_wide) smem[a[11:0] + 12'd1] = 8'(d >> 8);
                    exp_q.push_back({16'(a), 16'(d)});
                end
        push(32'h0941_0000);
        push({16'(y), 16'(x)});
        push({16'(h), 16'(w)});
    endtask

    // Driver for a copy in the chosen scan direction (R2, R3).
    task automatic do_copy(input int sx, input int sy, input int dx, input int dy,
                           input int w, input int h, input bit xr, input bit yr);
        for (int jj = 0; jj < h; jj++)
            for (int ii = 0; ii < w; ii++) begin
                int xo, yo, sa, da, d;
                xo = xr ? w - 1 - ii : ii;
                yo = yr ? h - 1 - jj : jj;
                if (inwin(dx + xo, dy + yo)) begin
                    sa = paddr(sx + xo, sy + yo);
                    da = paddr(dx + xo, dy + yo);
                    d  = smem[sa[11:0]];
                    if (m_wide) d = d | (int'(smem[sa[11:0] + 12'd1]) << 8);
                    smem[da[11:0]] = 8'(d);
                    if (m_wide) smem[da[11:0] + 12'd1] = 8'(d >> 8);
                    exp_q.push_back({16'(da), 16'(d)});
                end
            end
        push({8'h0D, 6'b010001, yr, xr, 16'h0});
        push({16'(sy), 16'(sx)});
        push({16'(dy), 16'(dx)});
        push({16'(h), 16'(w)});
    endtask

    // Waits for the busy mask to clear, then checks nothing is left predicted.
    task automatic finish_cmd(input string req);
        int n = 0;
        while ((status & 32'h131) != 0 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check((status & 32'h131) == 0, "R10 idle after work", status, 32'h0);
        check(exp_q.size() == 0, req, 32'(exp_q.size()), 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4096; k++) begin
            mem[k]  = 8'(k * 7 + 3);
            smem[k] = 8'(k * 7 + 3);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state, R7 empty queue count
        check(free_slots == CW'(DEPTH), "R7 R11 reset free_slots", 32'(free_slots), DEPTH);
        check(status == 32'h0, "R11 reset status", status, 32'h0);
        check(!mem_en, "R11 reset mem idle", 32'(mem_en), 32'h0);

        // R5 R11: reset window clips at the screen corner
        wr_reg(3'd2, 32'h5A);
        do_fill(30, 14, 4, 4);
        finish_cmd("R5 R11 reset clip window");

        // R1 R4: plain 8-bit fill at a moved base
        wr_reg(3'd0, 32'h100);
        wr_reg(3'd2, 32'hA5);
        do_fill(3, 2, 4, 3);
        check((status & 32'h131) != 0, "R10 busy while queued", status, 32'h131);
        finish_cmd("R1 fill completed");

        // R6: zero width and zero height
        do_fill(2, 2, 0, 5);
        finish_cmd("R6 zero width fill");
        do_copy(0, 0, 5, 5, 3, 0, 1'b0, 1'b0);
        finish_cmd("R6 zero height copy");

        // R5: narrowed window
        wr_reg(3'd4, 5); wr_reg(3'd5, 8); wr_reg(3'd6, 1); wr_reg(3'd7, 2);
        do_fill(3, 0, 8, 5);
        finish_cmd("R5 clipped fill");
        wr_reg(3'd4, 0); wr_reg(3'd5, SW - 1); wr_reg(3'd6, 0); wr_reg(3'd7, SH - 1);

        // R2: forward copy, no overlap
        do_copy(0, 0, 10, 5, 4, 3, 1'b0, 1'b0);
        finish_cmd("R2 forward copy");

        // R3: overlapping copy to the right, X reversed
        do_copy(2, 4, 4, 4, 6, 2, 1'b1, 1'b0);
        finish_cmd("R3 x-reversed overlap copy");

        // R3: overlapping copy downward, Y reversed
        do_copy(1, 2, 1, 4, 3, 4, 1'b0, 1'b1);
        finish_cmd("R3 y-reversed overlap copy");

        // R4: 16-bit pixels, fill then both-reversed copy
        wr_reg(3'd3, 32'h8000);
        wr_reg(3'd0, 32'h200);
        wr_reg(3'd2, 32'h1234);
        do_fill(1, 1, 3, 2);
        finish_cmd("R4 16-bit fill");
        do_copy(2, 2, 3, 3, 4, 3, 1'b1, 1'b1);
        finish_cmd("R3 R4 16-bit reversed copy");
        wr_reg(3'd3, 32'h0);

        // R9: unknown header dropped, next word decoded as header
        push(32'h1234_5678);
        @(negedge clk);
        check(status[31], "R9 bad header flag", status, 32'h8000_0000);
        wr_reg(3'd2, 32'h3C);
        do_fill(6, 6, 2, 2);
        finish_cmd("R9 resync after bad header");

        // R7 R8: fill the queue behind a long job, then overrun it
        do_fill(0, 0, SW, SH);
        do_fill(1, 1, 2, 1);
        do_fill(5, 5, 1, 1);
        exp_q.push_back({16'(paddr(7, 7)), 16'(m_fg & 8'hFF)});
        smem[paddr(7, 7)] = 8'(m_fg);
        push(32'h0941_0000);
        check(free_slots == '0, "R7 queue full count", 32'(free_slots), 32'h0);
        check(status[30] == 1'b0, "R8 no overflow yet", status, 32'h0);
        cmd_we = 1'b1; cmd_wdata = 32'h0000_0003;
        @(negedge clk);
        cmd_we = 1'b0;
        check(status[30], "R8 overflow flag", status, 32'h4000_0000);
        check(free_slots == '0, "R8 dropped write not queued", 32'(free_slots), 32'h0);
        push({16'd7, 16'd7});
        push({16'd1, 16'd1});
        finish_cmd("R8 R7 queued jobs completed");
        check(free_slots == CW'(DEPTH), "R7 drained count", 32'(free_slots), DEPTH);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule